// File: doc/BRIEF.md
# Flash Byte-Program Command Sequencer

This block watches the stream of write events that a flash bus interface delivers, one event per clock in which `wr_valid` is high. Each event carries an address and a data byte. The block looks for a fixed three-write unlock prefix: AAh to 5555h, then 55h to 2AAAh, then A0h to 5555h. Once that prefix is complete, the next accepted write is the byte to program. The block issues it as a single program request with the write's own address and data.

Any write that breaks the prefix sends the sequencer back to the start. The exception is a breaking write that is itself a valid first step: it counts as step one. After a request, the block holds `busy` high for a fixed number of clocks, and it ignores writes during that time. The array-side programming timing is left to whatever consumes the request. Erase commands and identification reads are also out of scope.

Top module: `byte_prog_seq`

## Requirements
- R1: A cycle with `rst` or `init` high leaves the block idle. After that clock edge, `busy` and `prog_req` are 0 and any partial prefix is discarded. `rst` also clears `prog_addr` and `prog_data` to 0, while `init` leaves them unchanged.
- R2: Step matching compares only address bits [14:0]. A write to 0xD5555 counts as a write to 5555h, and a write to 0x7AAAA counts as a write to 2AAAh.
- R3: The prefix is AAh to 5555h, then 55h to 2AAAh, then A0h to 5555h. The next accepted write raises `prog_req` for exactly one clock, in the cycle after that write's edge. In that same cycle, `prog_addr` and `prog_data` equal that write's full address and data. After the request the sequencer is back at the start.
- R4: An accepted write that does not match the expected step, and is not AAh to 5555h, returns the sequencer to the start.
- R5: An accepted mismatching write that is AAh to 5555h leaves the sequencer expecting step two.
- R6: `busy` is high for exactly BUSY_CYCLES consecutive cycles, starting in the cycle where `prog_req` is high. Only `init` or `rst` can end it early.
- R7: A write presented in a cycle where `busy` is high is ignored. It neither advances nor resets the prefix, and it never raises `prog_req`.
- R8: `prog_addr` and `prog_data` keep their values in every cycle where `prog_req` is low.
- R9: Cycles with `wr_valid` low leave the prefix progress unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Synchronous re-initialise: sequencer to start, busy cleared |
| wr_valid | input | 1 | A write event is present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data byte |
| prog_req | output | 1 | One-clock program request |
| prog_addr | output | ADDR_W | Address of the byte to program |
| prog_data | output | DATA_W | Data byte to program |
| busy | output | 1 | Program in progress; writes are ignored |

## Verification
The directed patterns cover several distinct cases:
- A clean prefix with high address bits set, which separates a 15-bit compare from a full-width compare.
- A prefix broken at step two by an unrelated write, and a prefix broken by a fresh AAh to 5555h, which separate a plain restart from a restart that keeps step one.
- A complete prefix written while `busy` is high, which shows whether busy writes are really dropped rather than counted.
- Idle gaps between steps, and `init` in the middle of a prefix.

On top of these, random traffic is biased toward the next expected step and checked every cycle against a reference model in the bench.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_GOT1  = 2'd1,
    ST_GOT2  = 2'd2,
    ST_ARMED = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic first;   // AAh to 5555h
    logic second;  // 55h to 2AAAh
    logic third;   // A0h to 5555h
  } step_hits_t;

  localparam int          CMP_W      = 15;
  localparam logic [14:0] LOCK_ADR_A = 15'h5555;
  localparam logic [14:0] LOCK_ADR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_FIRST  = 8'hAA;
  localparam logic [7:0]  KEY_SECOND = 8'h55;
  localparam logic [7:0]  KEY_THIRD  = 8'hA0;
endpackage

// File: rtl/bps_step_decode.sv
module bps_step_decode
  import bps_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output step_hits_t        hits
);
  logic [CMP_W-1:0] low_adr;
  logic             at_a;
  logic             at_b;

  assign low_adr = addr[CMP_W-1:0];
  assign at_a    = (low_adr == LOCK_ADR_A);
  assign at_b    = (low_adr == LOCK_ADR_B);

  always_comb begin
    hits.first  = at_a && (data[7:0] == KEY_FIRST);
    hits.second = at_b && (data[7:0] == KEY_SECOND);
    hits.third  = at_a && (data[7:0] == KEY_THIRD);
  end
endmodule

// File: rtl/bps_seq_fsm.sv
module bps_seq_fsm
  import bps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       wr_ok,
  input  step_hits_t hits,
  output logic       fire
);
  seq_state_t state_q;
  seq_state_t state_d;

  always_comb begin
    state_d = state_q;
    fire    = 1'b0;
    if (wr_ok) begin
      unique case (state_q)
        ST_START: state_d = hits.first ? ST_GOT1 : ST_START;
        ST_GOT1:  state_d = hits.second ? ST_GOT2 :
                            (hits.first ? ST_GOT1 : ST_START);
        ST_GOT2:  state_d = hits.third ? ST_ARMED :
                            (hits.first ? ST_GOT1 : ST_START);
        ST_ARMED: begin
          state_d = ST_START;
          fire    = 1'b1;
        end
        default:  state_d = ST_START;
      endcase
    end
    if (clear) begin
      state_d = ST_START;
      fire    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_START;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/bps_busy_timer.sv
module bps_busy_timer #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      busy   <= 1'b0;
      left_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      left_q <= LOAD;
    end else if (busy) begin
      if (left_q == '0) busy <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/byte_prog_seq.sv
module byte_prog_seq
  import bps_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              busy
);
  step_hits_t hits;
  logic       wr_ok;
  logic       fire;

  assign wr_ok = wr_valid && !busy && !init;

  bps_step_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .addr (wr_addr),
    .data (wr_data),
    .hits (hits)
  );

  bps_seq_fsm u_fsm (
    .clk   (clk),
    .rst   (rst),
    .clear (init),
    .wr_ok (wr_ok),
    .hits  (hits),
    .fire  (fire)
  );

  bps_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .clear (init),
    .start (fire),
    .busy  (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_req  <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
    end else begin
      prog_req <= fire;
      if (fire) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/bps_checker.sv
module bps_checker #(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              init,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              prog_req,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [DATA_W-1:0] prog_data,
  input logic              busy
);
  logic [31:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)       run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= '0;
  end

  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    prog_req |=> !prog_req);

  assert_req_source_R3: assert property (@(posedge clk) disable iff (rst)
    prog_req |-> ($past(wr_valid) && !$past(busy) && !$past(init)));

  assert_req_payload_R3: assert property (@(posedge clk) disable iff (rst)
    prog_req |-> (prog_addr == $past(wr_addr) && prog_data == $past(wr_data)));

  assert_req_busy_R6: assert property (@(posedge clk) disable iff (rst)
    prog_req |-> busy);

  assert_busy_bound_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_cnt < BUSY_CYCLES));

  assert_busy_length_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(init)) |-> (run_cnt == BUSY_CYCLES));

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> !prog_req);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !prog_req |-> ($stable(prog_addr) && $stable(prog_data)));

  assert_init_idle_R1: assert property (@(posedge clk) disable iff (rst)
    init |=> (!busy && !prog_req));
endmodule

bind byte_prog_seq bps_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .init(init), .wr_valid(wr_valid),
  .wr_addr(wr_addr), .wr_data(wr_data), .prog_req(prog_req),
  .prog_addr(prog_addr), .prog_data(prog_data), .busy(busy)
);

// File: tb/byte_prog_seq_test.sv
module byte_prog_seq_test;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int TB_BUSY = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          init = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          prog_req;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic          busy;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model
  int            m_state = 0;
  int            m_left = 0;
  logic [AW-1:0] e_addr = '0;
  logic [DW-1:0] e_data = '0;

  always #2.5 clk = ~clk;

  byte_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(TB_BUSY)) uut (
    .clk(clk), .rst(rst), .init(init), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data), .busy(busy)
  );

  function automatic bit f_hit1(logic [AW-1:0] a, logic [DW-1:0] d);
    return (a[14:0] == 15'h5555) && (d == 8'hAA);
  endfunction
  function automatic bit f_hit2(logic [AW-1:0] a, logic [DW-1:0] d);
    return (a[14:0] == 15'h2AAA) && (d == 8'h55);
  endfunction
  function automatic bit f_hit3(logic [AW-1:0] a, logic [DW-1:0] d);
    return (a[14:0] == 15'h5555) && (d == 8'hA0);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock with an optional write, checked against the model
  task automatic step(bit v, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    bit exp_req = 1'b0;
    bit was_busy;
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d; init = 1'b0;
    was_busy = (m_left > 0);
    if (v && !was_busy) begin
      case (m_state)
        0: m_state = f_hit1(a, d) ? 1 : 0;
        1: m_state = f_hit2(a, d) ? 2 : (f_hit1(a, d) ? 1 : 0);
        2: m_state = f_hit3(a, d) ? 3 : (f_hit1(a, d) ? 1 : 0);
        default: begin exp_req = 1'b1; m_state = 0; end
      endcase
    end
    if (exp_req) begin
      m_left = TB_BUSY; e_addr = a; e_data = d;
    end else if (m_left > 0) begin
      m_left--;
    end
    @(posedge clk); #1;
    chk(prog_req == exp_req, (v && was_busy) ? "R7 req" : {tag, " req"},
        32'(prog_req), 32'(exp_req));
    chk(busy == (m_left > 0), "R6 busy", 32'(busy), 32'(m_left > 0));
    chk(prog_addr == e_addr, exp_req ? "R3 addr" : "R8 addr", 32'(prog_addr), 32'(e_addr));
    chk(prog_data == e_data, exp_req ? "R3 data" : "R8 data", 32'(prog_data), 32'(e_data));
  endtask

  task automatic do_init(bit v, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    init = 1'b1; wr_valid = v; wr_addr = a; wr_data = d;
    m_state = 0; m_left = 0;
    @(posedge clk); #1;
    chk(!busy, "R1 init busy", 32'(busy), 0);
    chk(!prog_req, "R1 init req", 32'(prog_req), 0);
    chk(prog_addr == e_addr, "R1 init keeps addr", 32'(prog_addr), 32'(e_addr));
    @(negedge clk); init = 1'b0; wr_valid = 1'b0;
  endtask

  task automatic prefix(logic [4:0] hi);
    step(1, {hi, 15'h5555}, 8'hAA, "R3");
    step(1, {hi, 15'h2AAA}, 8'h55, "R3");
    step(1, {hi, 15'h5555}, 8'hA0, "R3");
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, '0, "R9");
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    #1;
    chk(!busy && !prog_req, "R1 reset idle", 32'({busy, prog_req}), 0);
    chk(prog_addr == '0 && prog_data == '0, "R1 reset payload",
        32'(prog_addr), 0);
    @(negedge clk); rst = 1'b0;

    // R3: plain prefix and program
    prefix(5'h00);
    step(1, 20'h01234, 8'h3C, "R3");
    idle(TB_BUSY + 1);

    // R2: upper address bits ignored in matching
    prefix(5'h1A);
    step(1, 20'hF0F0F, 8'h81, "R2");
    idle(TB_BUSY + 1);

    // R4: broken at step two by unrelated write
    step(1, 20'h05555, 8'hAA, "R4");
    step(1, 20'h00100, 8'h55, "R4");
    step(1, 20'h05555, 8'hA0, "R4");
    step(1, 20'h00200, 8'h11, "R4");
    idle(2);

    // R5: mismatch that is itself a first step
    step(1, 20'h05555, 8'hAA, "R5");
    step(1, 20'h05555, 8'hAA, "R5");
    step(1, 20'h02AAA, 8'h55, "R5");
    step(1, 20'h05555, 8'hA0, "R5");
    step(1, 20'h00ABC, 8'h5A, "R5");
    idle(TB_BUSY + 1);

    // R9: gaps between steps
    step(1, 20'h05555, 8'hAA, "R9"); idle(3);
    step(1, 20'h02AAA, 8'h55, "R9"); idle(2);
    step(1, 20'h05555, 8'hA0, "R9"); idle(4);
    step(1, 20'h0BEEF, 8'h77, "R9");
    // R7: full prefix and target while busy, then one more write
    prefix(5'h00);
    step(1, 20'h00055, 8'h99, "R7");
    idle(TB_BUSY);
    step(1, 20'h00066, 8'h44, "R7");

    // R1: init mid-prefix discards progress
    step(1, 20'h05555, 8'hAA, "R1");
    step(1, 20'h02AAA, 8'h55, "R1");
    step(1, 20'h05555, 8'hA0, "R1");
    do_init(1, 20'h00777, 8'h12);
    step(1, 20'h00777, 8'h12, "R1");
    // R1: init while busy ends busy
    prefix(5'h03);
    step(1, 20'h00321, 8'hE1, "R3");
    idle(1);
    do_init(0, '0, '0);

    // random traffic biased toward the next expected step
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int pick;
      a = AW'($urandom);
      d = DW'($urandom);
      pick = $urandom_range(0, 9);
      if (pick < 5) begin
        case (m_state)
          0: begin a[14:0] = 15'h5555; d = 8'hAA; end
          1: begin a[14:0] = 15'h2AAA; d = 8'h55; end
          2: begin a[14:0] = 15'h5555; d = 8'hA0; end
          default: ;
        endcase
      end else if (pick == 5) begin
        a[14:0] = 15'h5555; d = 8'hAA;
      end
      if ($urandom_range(0, 299) == 0) do_init($urandom_range(0, 1), a, d);
      else step($urandom_range(0, 3) != 0, a, d, "R3");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule